// File: doc/BRIEF.md
# Circular Sample Memory Sequencer

This block drives the digital side of a ring of analog sample cells shared by a set of signal channels and a few reference channels. While sampling, it steps a write pointer through the ring, one cell per clock, and wraps from the last cell back to cell 0. A trigger on either of two inputs (one external, one local) stops sampling and holds the pointer. The held pointer then names the oldest stored cell.

A readout request then replays the stored columns in time order. The frame opens with a fixed header. For each column, the block presents the column address for a fixed number of overhead cycles, then steps a channel select through every chosen channel, one per clock. A fixed trailer follows, during which the last column read is shown on its own output. A one-cycle done pulse closes the frame.

The readout depth can be the full ring or one of two shorter windows that hold only the most recent samples. The channel set can be every channel, the channels flagged in a hit vector, or the channels flagged in a selection vector. The whole block runs in a single clock domain.

Top module: `sample_ring_ctrl`

## Requirements
- R1: While sampling (`writing` high), `wrPtr` rises by one on each clock and goes from CELLS-1 to 0. A `writeEn` pulse in the idle state starts sampling on the next edge, with the pointer value it held before.
- R2: When `trigExt` or `trigLocal` is high at an edge while sampling, sampling stops at that edge without a further advance, and `frozen` goes high with `wrPtr` held. A trigger in any other state has no effect.
- R3: `readStart` while frozen starts a frame. Its first HDR cycles are a header with `chanValid` and `lastColValid` low. `readStart` in any other state has no effect, and so do `writeEn` and the triggers during a frame.
- R4: At full depth the frame visits CELLS columns. It starts at the frozen pointer value and ascends modulo CELLS.
- R5: `depthSel` selects the depth: 0 or 3 gives the full ring, 1 gives DEPTH_MID and 2 gives DEPTH_LOW. A depth D starts at (frozen pointer − D) mod CELLS, so the last column is always the newest sample.
- R6: Each column gives OVH cycles with `chanValid` low and then one cycle with `chanValid` high for each chosen channel, in ascending index. `colAddr` holds the column throughout.
- R7: `chanMode` 0 or 3 chooses all NSIG+NDUM channels, where indices NSIG and up are the reference channels. Mode 1 chooses signal channel i where `hitMask[i]` is set, and mode 2 where `selMask[i]` is set. Reference channels are not read in modes 1 and 2.
- R8: `reading` stays high for exactly HDR + D×(OVH+n) + TRL cycles, where n is the number of chosen channels. With the defaults, one channel at full depth gives 2123 cycles.
- R9: During the last TRL cycles `lastColValid` is high and `lastCol` equals (frozen pointer − 1) mod CELLS. `done` is high only in the final frame cycle. The block then idles until a new `writeEn`.
- R10: After reset, the block is idle: `wrPtr` is 0 and `writing`, `frozen`, `reading`, `chanValid`, `lastColValid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling and readout clock |
| rstN | input | 1 | Active-low synchronous reset |
| writeEn | input | 1 | Start sampling (idle state only) |
| trigExt | input | 1 | External stop trigger |
| trigLocal | input | 1 | Local stop trigger |
| readStart | input | 1 | Start readout frame (frozen state only) |
| depthSel | input | 2 | Readout depth code |
| chanMode | input | 2 | Channel set code |
| hitMask | input | NSIG | Hit flags per signal channel |
| selMask | input | NSIG | Chosen flags per signal channel |
| writing | output | 1 | Sampling in progress |
| frozen | output | 1 | Pointer held, awaiting readout |
| wrPtr | output | clog2(CELLS) | Write pointer |
| reading | output | 1 | Readout frame in progress |
| colAddr | output | clog2(CELLS) | Column being read |
| chanValid | output | 1 | Channel cycle of a column |
| chanSel | output | clog2(NSIG+NDUM) | Channel being read |
| lastColValid | output | 1 | Trailer cycle |
| lastCol | output | clog2(CELLS) | Last column read (trailer only, else 0) |
| done | output | 1 | Final cycle of the frame |

## Verification
The bench sweeps every depth code against every channel mode on a small ring. Sampling run lengths vary so that the frozen pointer lands in many positions, both before and after wraps. The unused codes 3 are included, which separates the decoding of the two fields from their default arms. Sparse, dense and empty masks show whether the channel walk skips unchosen channels and whether an empty set still yields the column overheads. Stray triggers, write requests and read requests in the wrong state show whether each phase ignores what it should.

// File: rtl/sample_ring_pkg.sv
package sample_ring_pkg;

  typedef struct packed {
    logic ptrAdvance;
    logic loadRead;
    logic colStep;
    logic chanFirst;
    logic chanNext;
  } ringStrobes_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITE,
    ST_FROZEN,
    ST_HEAD,
    ST_COLOVH,
    ST_CHAN,
    ST_TRAIL
  } ringState_t;

endpackage

// File: rtl/sample_ring_dp.sv
module sample_ring_dp
  import sample_ring_pkg::*;
#(
  parameter int CELLS     = 511,
  parameter int DEPTH_MID = 256,
  parameter int DEPTH_LOW = 128,
  parameter int NSIG      = 72,
  parameter int NDUM      = 4,
  localparam int CW  = $clog2(CELLS),
  localparam int NCH = NSIG + NDUM,
  localparam int CHW = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rstN,
  input  ringStrobes_t    strb,
  input  logic [1:0]      depthSel,
  input  logic [1:0]      chanMode,
  input  logic [NSIG-1:0] hitMask,
  input  logic [NSIG-1:0] selMask,
  output logic [CW-1:0]   wrPtr,
  output logic [CW-1:0]   colAddr,
  output logic [CHW-1:0]  chanSel,
  output logic            hasAny,
  output logic            hasNext,
  output logic            isLastCol
);

  logic [NCH-1:0] selVec;
  logic [NCH-1:0] newSel;
  logic [CW:0]    depthLen;
  logic [CW:0]    startSum;
  logic [CW-1:0]  startCol;
  logic [CW-1:0]  newestCol;
  logic [CHW-1:0] firstIdx;
  logic [CHW-1:0] nextIdx;

  function automatic logic [CW-1:0] ringInc(input logic [CW-1:0] v);
    return (v == CW'(CELLS - 1)) ? '0 : v + 1'b1;
  endfunction

  always_comb begin
    unique case (depthSel)
      2'd1:    depthLen = (CW+1)'(DEPTH_MID);
      2'd2:    depthLen = (CW+1)'(DEPTH_LOW);
      default: depthLen = (CW+1)'(CELLS);
    endcase
    startSum = {1'b0, wrPtr} + (CW+1)'(CELLS) - depthLen;
    startCol = (startSum >= (CW+1)'(CELLS)) ? CW'(startSum - (CW+1)'(CELLS)) : CW'(startSum);
    newestCol = (wrPtr == '0) ? CW'(CELLS - 1) : wrPtr - 1'b1;
  end

  always_comb begin
    unique case (chanMode)
      2'd1:    newSel = {{NDUM{1'b0}}, hitMask};
      2'd2:    newSel = {{NDUM{1'b0}}, selMask};
      default: newSel = '1;
    endcase
  end

  always_comb begin
    firstIdx = '0;
    nextIdx  = '0;
    hasNext  = 1'b0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (selVec[i]) firstIdx = CHW'(i);
      if (selVec[i] && (CHW'(i) > chanSel)) begin
        nextIdx = CHW'(i);
        hasNext = 1'b1;
      end
    end
  end

  assign hasAny    = |selVec;
  assign isLastCol = (colAddr == newestCol);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr   <= '0;
      colAddr <= '0;
      chanSel <= '0;
      selVec  <= '0;
    end else begin
      if (strb.ptrAdvance) wrPtr <= ringInc(wrPtr);
      if (strb.loadRead) begin
        colAddr <= startCol;
        selVec  <= newSel;
      end else if (strb.colStep) begin
        colAddr <= ringInc(colAddr);
      end
      if (strb.chanFirst)     chanSel <= firstIdx;
      else if (strb.chanNext) chanSel <= nextIdx;
    end
  end

  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    wrPtr < CW'(CELLS)); // R1
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ptrAdvance && wrPtr == CW'(CELLS - 1)) |=> (wrPtr == '0)); // R1
  AST_PTR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.ptrAdvance |=> $stable(wrPtr)); // R2
  AST_COL_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    colAddr < CW'(CELLS)); // R4
  AST_CHAN_CHOSEN: assert property (@(posedge clk) disable iff (!rstN)
    (strb.chanFirst || strb.chanNext) |=> selVec[chanSel]); // R7

endmodule

// File: rtl/sample_ring_fsm.sv
module sample_ring_fsm
  import sample_ring_pkg::*;
#(
  parameter int HDR = 9,
  parameter int OVH = 3,
  parameter int TRL = 70,
  localparam int MAXP = (HDR > OVH) ? ((HDR > TRL) ? HDR : TRL) : ((OVH > TRL) ? OVH : TRL),
  localparam int PW   = $clog2(MAXP + 1)
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         writeEn,
  input  logic         trigExt,
  input  logic         trigLocal,
  input  logic         readStart,
  input  logic         hasAny,
  input  logic         hasNext,
  input  logic         isLastCol,
  output ringStrobes_t strb,
  output logic         writing,
  output logic         frozen,
  output logic         reading,
  output logic         chanValid,
  output logic         lastColValid,
  output logic         done
);

  ringState_t state, stateNxt;
  logic [PW-1:0] cnt, cntNxt;
  logic trig;

  assign trig = trigExt | trigLocal;

  always_comb begin
    stateNxt = state;
    cntNxt   = cnt + 1'b1;
    strb     = '0;
    unique case (state)
      ST_IDLE: if (writeEn) stateNxt = ST_WRITE;
      ST_WRITE: begin
        if (trig) stateNxt = ST_FROZEN;
        else      strb.ptrAdvance = 1'b1;
      end
      ST_FROZEN: if (readStart) begin
        stateNxt = ST_HEAD;
        strb.loadRead = 1'b1;
        cntNxt = '0;
      end
      ST_HEAD: if (cnt == PW'(HDR - 1)) begin
        stateNxt = ST_COLOVH;
        cntNxt = '0;
      end
      ST_COLOVH: if (cnt == PW'(OVH - 1)) begin
        cntNxt = '0;
        if (hasAny) begin
          stateNxt = ST_CHAN;
          strb.chanFirst = 1'b1;
        end else if (isLastCol) begin
          stateNxt = ST_TRAIL;
        end else begin
          strb.colStep = 1'b1;
        end
      end
      ST_CHAN: begin
        cntNxt = '0;
        if (hasNext) begin
          strb.chanNext = 1'b1;
        end else if (isLastCol) begin
          stateNxt = ST_TRAIL;
        end else begin
          stateNxt = ST_COLOVH;
          strb.colStep = 1'b1;
        end
      end
      ST_TRAIL: if (cnt == PW'(TRL - 1)) stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNxt;
      cnt   <= cntNxt;
    end
  end

  assign writing      = (state == ST_WRITE);
  assign frozen       = (state == ST_FROZEN);
  assign reading      = (state == ST_HEAD) || (state == ST_COLOVH) || (state == ST_CHAN) || (state == ST_TRAIL);
  assign chanValid    = (state == ST_CHAN);
  assign lastColValid = (state == ST_TRAIL);
  assign done         = (state == ST_TRAIL) && (cnt == PW'(TRL - 1));

  AST_TRIG_FREEZES: assert property (@(posedge clk) disable iff (!rstN)
    (writing && trig) |=> frozen); // R2
  AST_PHASE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({writing, frozen, reading})); // R3
  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!reading && !writing && !frozen)); // R9
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !writeEn) |=> (state == ST_IDLE)); // R9
  AST_FROZEN_WAITS: assert property (@(posedge clk) disable iff (!rstN)
    (frozen && !readStart) |=> frozen); // R3

endmodule

// File: rtl/sample_ring_ctrl.sv
module sample_ring_ctrl
  import sample_ring_pkg::*;
#(
  parameter int CELLS     = 511,
  parameter int DEPTH_MID = 256,
  parameter int DEPTH_LOW = 128,
  parameter int NSIG      = 72,
  parameter int NDUM      = 4,
  parameter int HDR       = 9,
  parameter int OVH       = 3,
  parameter int TRL       = 70,
  localparam int CW  = $clog2(CELLS),
  localparam int CHW = $clog2(NSIG + NDUM)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            writeEn,
  input  logic            trigExt,
  input  logic            trigLocal,
  input  logic            readStart,
  input  logic [1:0]      depthSel,
  input  logic [1:0]      chanMode,
  input  logic [NSIG-1:0] hitMask,
  input  logic [NSIG-1:0] selMask,
  output logic            writing,
  output logic            frozen,
  output logic [CW-1:0]   wrPtr,
  output logic            reading,
  output logic [CW-1:0]   colAddr,
  output logic            chanValid,
  output logic [CHW-1:0]  chanSel,
  output logic            lastColValid,
  output logic [CW-1:0]   lastCol,
  output logic            done
);

  ringStrobes_t strb;
  logic hasAny, hasNext, isLastCol;

  sample_ring_fsm #(.HDR(HDR), .OVH(OVH), .TRL(TRL)) fsm_i (
    .clk(clk), .rstN(rstN), .writeEn(writeEn), .trigExt(trigExt),
    .trigLocal(trigLocal), .readStart(readStart), .hasAny(hasAny),
    .hasNext(hasNext), .isLastCol(isLastCol), .strb(strb),
    .writing(writing), .frozen(frozen), .reading(reading),
    .chanValid(chanValid), .lastColValid(lastColValid), .done(done)
  );

  sample_ring_dp #(.CELLS(CELLS), .DEPTH_MID(DEPTH_MID), .DEPTH_LOW(DEPTH_LOW),
                   .NSIG(NSIG), .NDUM(NDUM)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .depthSel(depthSel),
    .chanMode(chanMode), .hitMask(hitMask), .selMask(selMask),
    .wrPtr(wrPtr), .colAddr(colAddr), .chanSel(chanSel),
    .hasAny(hasAny), .hasNext(hasNext), .isLastCol(isLastCol)
  );

  assign lastCol = lastColValid ? colAddr : '0;

endmodule

// File: tb/sample_ring_ctrl_tb_top.sv
`timescale 1ns/1ps
module sample_ring_ctrl_tb_top;

  localparam int CELLS = 13;
  localparam int DMID  = 6;
  localparam int DLOW  = 3;
  localparam int NSIG  = 5;
  localparam int NDUM  = 2;
  localparam int NCH   = NSIG + NDUM;
  localparam int HDR   = 2;
  localparam int OVH   = 3;
  localparam int TRL   = 3;
  localparam int CW    = $clog2(CELLS);
  localparam int CHW   = $clog2(NCH);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic writeEn = 1'b0, trigExt = 1'b0, trigLocal = 1'b0, readStart = 1'b0;
  logic [1:0] depthSel = '0, chanMode = '0;
  logic [NSIG-1:0] hitMask = '0, selMask = '0;
  logic writing, frozen, reading, chanValid, lastColValid, done;
  logic [CW-1:0] wrPtr, colAddr, lastCol;
  logic [CHW-1:0] chanSel;

  int nChecks = 0;
  int nFails  = 0;
  int p0 = 0;
  int expCol[0:127];
  int expCh[0:127];

  always #10 clk = ~clk;

  sample_ring_ctrl #(.CELLS(CELLS), .DEPTH_MID(DMID), .DEPTH_LOW(DLOW), .NSIG(NSIG),
                     .NDUM(NDUM), .HDR(HDR), .OVH(OVH), .TRL(TRL)) dut_i (
    .clk(clk), .rstN(rstN), .writeEn(writeEn), .trigExt(trigExt), .trigLocal(trigLocal),
    .readStart(readStart), .depthSel(depthSel), .chanMode(chanMode), .hitMask(hitMask),
    .selMask(selMask), .writing(writing), .frozen(frozen), .wrPtr(wrPtr), .reading(reading),
    .colAddr(colAddr), .chanValid(chanValid), .chanSel(chanSel), .lastColValid(lastColValid),
    .lastCol(lastCol), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic runFrame(input int k, input bit useLocal, input int dsel, input int cmode,
                          input logic [NSIG-1:0] hm, input logic [NSIG-1:0] sm);
    int depth, stopPtr, start, nSel, nExp, expLen, lastExp;
    int count, idx, trail, doneCnt, doneAt;
    bit sel[NCH];
    depth = (dsel == 1) ? DMID : (dsel == 2) ? DLOW : CELLS;
    for (int c = 0; c < NCH; c++)
      sel[c] = (cmode == 1) ? (c < NSIG && hm[c]) : (cmode == 2) ? (c < NSIG && sm[c]) : 1'b1;
    nSel = 0;
    for (int c = 0; c < NCH; c++) if (sel[c]) nSel++;
    // sampling phase
    @(negedge clk); writeEn = 1'b1;
    for (int i = 0; i <= k; i++) begin
      @(negedge clk);
      if (i == 0) writeEn = 1'b0;
      readStart = (i == 1);
      chk(writing && wrPtr == CW'((p0 + i) % CELLS), "R1", wrPtr, (p0 + i) % CELLS);
      chk(!reading, "R3", reading, 0);
      if (i == k) begin
        if (useLocal) trigLocal = 1'b1; else trigExt = 1'b1;
      end
    end
    @(negedge clk);
    trigLocal = 1'b0; trigExt = 1'b0; readStart = 1'b0;
    stopPtr = (p0 + k) % CELLS;
    chk(frozen && !writing, "R2", frozen, 1);
    chk(wrPtr == CW'(stopPtr), "R2", wrPtr, stopPtr);
    @(negedge clk);
    chk(frozen && wrPtr == CW'(stopPtr), "R2", wrPtr, stopPtr);
    // expected sequence
    start = (stopPtr + CELLS - depth) % CELLS;
    lastExp = (stopPtr + CELLS - 1) % CELLS;
    nExp = 0;
    for (int c = 0; c < depth; c++)
      for (int ch = 0; ch < NCH; ch++)
        if (sel[ch]) begin
          expCol[nExp] = (start + c) % CELLS;
          expCh[nExp] = ch;
          nExp++;
        end
    expLen = HDR + depth * (OVH + nSel) + TRL;
    depthSel = 2'(dsel); chanMode = 2'(cmode); hitMask = hm; selMask = sm;
    readStart = 1'b1;
    @(negedge clk);
    readStart = 1'b0;
    count = 0; idx = 0; trail = 0; doneCnt = 0; doneAt = 0;
    for (int g = 0; g < 5000 && reading; g++) begin
      count++;
      writeEn = (count == 1);
      trigExt = (count == 2);
      chk(!writing && !frozen, "R3", writing, 0);
      if (count <= HDR) chk(!chanValid && !lastColValid, "R3", chanValid, 0);
      if (count == HDR + 1) begin
        if (dsel == 1 || dsel == 2) chk(colAddr == CW'(start), "R5", colAddr, start);
        else chk(colAddr == CW'(start), "R4", colAddr, start);
      end
      if (chanValid) begin
        if (idx < nExp)
          chk(colAddr == CW'(expCol[idx]) && chanSel == CHW'(expCh[idx]), "R6",
              colAddr * 100 + chanSel, expCol[idx] * 100 + expCh[idx]);
        else
          chk(1'b0, "R7", idx, nExp);
        idx++;
      end
      if (lastColValid) begin
        trail++;
        chk(lastCol == CW'(lastExp), "R9", lastCol, lastExp);
      end
      if (done) begin doneCnt++; doneAt = count; end
      @(negedge clk);
    end
    writeEn = 1'b0; trigExt = 1'b0;
    chk(count == expLen, "R8", count, expLen);
    chk(idx == nExp, "R7", idx, nExp);
    chk(trail == TRL, "R9", trail, TRL);
    chk(doneCnt == 1 && doneAt == count, "R9", doneAt, count);
    chk(!writing && !frozen && !reading, "R9", writing, 0);
    @(negedge clk);
    chk(!writing && wrPtr == CW'(stopPtr), "R9", wrPtr, stopPtr);
    p0 = stopPtr;
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!writing && !frozen && !reading && !chanValid && !lastColValid && !done, "R10", writing, 0);
    chk(wrPtr == '0, "R10", wrPtr, 0);
    // triggers and read requests while idle
    trigExt = 1'b1; readStart = 1'b1;
    @(negedge clk);
    trigExt = 1'b0; trigLocal = 1'b1;
    @(negedge clk);
    trigLocal = 1'b0; readStart = 1'b0;
    chk(!frozen && !reading && !writing, "R2", frozen, 0);
    chk(wrPtr == '0, "R2", wrPtr, 0);
    for (int d = 0; d < 4; d++)
      for (int m = 0; m < 4; m++) begin
        int s;
        logic [NSIG-1:0] hm, sm;
        s = d * 4 + m;
        hm = NSIG'(s * 3 + 1);
        sm = (d == 1 && m == 2) ? '0 : NSIG'(s * 11 + 5);
        runFrame((s * 7) % 19 + 1, s[0], d, m, hm, sm);
      end
    runFrame(30, 1'b0, 2, 2, '0, NSIG'(1));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule